// File: doc/BRIEF.md
# Activity Monitor Standby Timer

This block watches system activity on behalf of power management. It holds three independent monitors. Each one runs an 8-bit down-counter that is advanced by its own tick prescaler, and an event recognizer that compares a 32-bit activity event vector against a per-monitor enable mask. Any enabled event puts the counter back to its programmed start value and restarts the prescaler. The monitor period is therefore always measured from the most recent activity.

If a monitor counts all the way to zero with no enabled event arriving, it sets a sticky expiry flag and stops at zero. The system management interrupt request is the OR of the three flags. Firmware sets up the monitors through a byte-wide write bus. It programs the start counts, the tick length selects and the event masks, and it reacts to the interrupt by dimming, throttling or sleeping the system. Those actions happen elsewhere.

Top module: `act_monitor`

## Requirements
- R1: The start count of monitors 0, 1 and 2 is written at bus addresses 79h, 7Ah and 7Bh. A write to a start-count address loads that count into the counter, restarts the prescaler and clears the expiry flag. It leaves the other monitors untouched.
- R2: Register 7Ch holds a 2-bit tick select for each monitor: bits [7:6] for monitor 0, [5:4] for monitor 1 and [3:2] for monitor 2. Bits [1:0] are unused. A select value g gives a tick of 2^(BASE_SHIFT + STEP_SHIFT*g) clocks, which is 2^8, 2^16, 2^24 or 2^32 clocks with the default parameters.
- R3: After a reload at clock edge E, with start count C and tick length L, the expiry flag of that monitor is low up to edge E+C*L-1 and goes high at edge E+C*L.
- R4: The 32-bit enable mask of monitor i is written byte by byte at 40h+4i (bits 7:0) up to 43h+4i (bits 31:24). When event bit j is high at a clock edge and mask bit j of monitor i is set, monitor i reloads at that edge.
- R5: An event bit whose mask bit is clear has no effect on that monitor's countdown.
- R6: A reload event at the same edge as the one that would cause expiry wins. The flag stays low and a new period starts.
- R7: A start count of zero disables the monitor. Its flag never rises, even when events arrive.
- R8: Once set, the expiry flag stays high and the counter stays at zero until an enabled event or a start-count write clears it.
- R9: `smi_req` is high exactly when at least one expiry flag is high.
- R10: After synchronous reset all start counts, masks and tick selects are zero, and all flags and `smi_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock (14.318 MHz in the system) |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| act_evt | input | 32 | Activity event vector, one bit per event source |
| expired | output | 3 | Sticky expiry flag per monitor |
| smi_req | output | 1 | Interrupt request, OR of the expiry flags |

## Verification
The countdown is tested with seeded random combinations of monitor, tick select, start count and enabled event bit. Each period is started either by a start-count write or by an event pulse. Checking the flag one edge before and exactly at C*L separates a wrong tick length or an off-by-one from a correct countdown. Directed cases then target the special conditions:
- an unmasked event in mid-period, which must not shift the expiry;
- a masked event in mid-period, which must shift it;
- an event on the very edge of expiry, where the event must win;
- a zero start count, which must keep the monitor disabled;
- the persistence of a set flag until the first clearing action.

// File: rtl/actmon_pkg.sv
package actmon_pkg;
    localparam int NUM_MON = 3;
    localparam int EVT_W   = 32;
    localparam int CNT_W   = 8;
    localparam int GRAN_W  = 2;
    localparam int NUM_SEL = 1 << GRAN_W;

    localparam logic [7:0] ADDR_INIT_BASE = 8'h79;
    localparam logic [7:0] ADDR_GRAN      = 8'h7C;
    localparam logic [7:0] ADDR_MASK_BASE = 8'h40;

    typedef struct packed {
        logic [CNT_W-1:0]  start;
        logic [GRAN_W-1:0] sel;
        logic [EVT_W-1:0]  mask;
    } mon_cfg_t;

    function automatic int unsigned tick_shift(input logic [GRAN_W-1:0] sel,
                                               input int unsigned base,
                                               input int unsigned step);
        return base + step * int'(sel);
    endfunction
endpackage

// File: rtl/actmon_regs.sv
module actmon_regs
    import actmon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output mon_cfg_t             cfg     [NUM_MON],
    output logic [NUM_MON-1:0]   start_wr
);
    localparam int BYTES = EVT_W / 8;

    for (genvar i = 0; i < NUM_MON; i++) begin : g_mon
        localparam logic [7:0] A_START = ADDR_INIT_BASE + 8'(i);
        localparam int         SEL_LO  = 6 - GRAN_W * i;

        assign start_wr[i] = reg_wr && (reg_addr == A_START);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i] <= '0;
            end else if (reg_wr) begin
                if (reg_addr == A_START)
                    cfg[i].start <= reg_wdata;
                if (reg_addr == ADDR_GRAN)
                    cfg[i].sel <= reg_wdata[SEL_LO +: GRAN_W];
                for (int b = 0; b < BYTES; b++) begin
                    if (reg_addr == ADDR_MASK_BASE + 8'(BYTES * i + b))
                        cfg[i].mask[8*b +: 8] <= reg_wdata;
                end
            end
        end
    end
endmodule

// File: rtl/actmon_prescaler.sv
module actmon_prescaler
    import actmon_pkg::*;
#(
    parameter int BASE_SHIFT = 8,
    parameter int STEP_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              run,
    input  logic [GRAN_W-1:0] sel,
    output logic              tick
);
    localparam int PRE_W = BASE_SHIFT + STEP_SHIFT * (NUM_SEL - 1);

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] msk;
    int unsigned      shift;

    always_comb begin
        shift = tick_shift(sel, BASE_SHIFT, STEP_SHIFT);
        for (int b = 0; b < PRE_W; b++)
            msk[b] = (b < int'(shift));
    end

    assign tick = run && ((pre & msk) == msk);

    always_ff @(posedge clk) begin
        if (rst || restart)
            pre <= '0;
        else if (run)
            pre <= pre + 1'b1;
    end
endmodule

// File: rtl/actmon_timer.sv
module actmon_timer
    import actmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] start,
    input  logic             tick,
    output logic             running,
    output logic             expired
);
    logic [CNT_W-1:0] count;

    assign running = (count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            expired <= 1'b0;
        end else if (load) begin
            count   <= start;
            expired <= 1'b0;
        end else if (tick && running) begin
            count <= count - 1'b1;
            if (count == CNT_W'(1))
                expired <= 1'b1;
        end
    end

    assert_rise_from_one_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(expired) |-> ($past(count) == CNT_W'(1)));

    assert_never_counts_up_R3: assert property (@(posedge clk) disable iff (rst)
        !load |=> (count <= $past(count)));

    assert_load_wins_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> (!expired && count == $past(start)));

    assert_sticky_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> (expired && count == '0));
endmodule

// File: rtl/act_monitor.sv
module act_monitor
    import actmon_pkg::*;
#(
    parameter int BASE_SHIFT = 8,
    parameter int STEP_SHIFT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [7:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    input  logic [EVT_W-1:0]   act_evt,
    output logic [NUM_MON-1:0] expired,
    output logic               smi_req
);
    mon_cfg_t           cfg [NUM_MON];
    logic [NUM_MON-1:0] start_wr;
    logic [NUM_MON-1:0] reload;
    logic [NUM_MON-1:0] restart;
    logic [NUM_MON-1:0] running;
    logic [NUM_MON-1:0] tick;

    actmon_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cfg       (cfg),
        .start_wr  (start_wr)
    );

    for (genvar i = 0; i < NUM_MON; i++) begin : g_mon
        // event recognizer: any enabled activity bit reloads this monitor
        assign reload[i]  = |(act_evt & cfg[i].mask);
        assign restart[i] = reload[i] || start_wr[i];

        actmon_prescaler #(
            .BASE_SHIFT (BASE_SHIFT),
            .STEP_SHIFT (STEP_SHIFT)
        ) u_pre (
            .clk     (clk),
            .rst     (rst),
            .restart (restart[i]),
            .run     (running[i]),
            .sel     (cfg[i].sel),
            .tick    (tick[i])
        );

        // start_wr loads the newly written byte, not the stored one
        actmon_timer u_tmr (
            .clk     (clk),
            .rst     (rst),
            .load    (restart[i]),
            .start   (start_wr[i] ? reg_wdata : cfg[i].start),
            .tick    (tick[i]),
            .running (running[i]),
            .expired (expired[i])
        );
    end

    assign smi_req = |expired;

    assert_smi_follows_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(smi_req) |-> ($countones(expired) != 0 && $countones($past(expired)) == 0));

    assert_zero_start_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (start_wr[0] && reg_wdata == 8'h00) |=> !expired[0]);
endmodule

// File: tb/tb_act_monitor.sv
module tb_act_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int BS = 2;
    localparam int SS = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [31:0] act_evt = '0;
    logic [2:0]  expired;
    logic        smi_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    act_monitor #(.BASE_SHIFT(BS), .STEP_SHIFT(SS)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .act_evt(act_evt), .expired(expired), .smi_req(smi_req)
    );

    function automatic int period(input int sel, input int start);
        return start << (BS + SS * sel);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // every task below is entered and left at a falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] v);
        act_evt = v;
        @(negedge clk);
        act_evt = '0;
    endtask

    task automatic set_mask(input int m, input logic [31:0] v);
        for (int b = 0; b < 4; b++)
            wr(8'h40 + 8'(4*m + b), v[8*b +: 8]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int m = 0; m < 3; m++) wr(8'h79 + 8'(m), 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R3 watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd24680));
        idle(3);
        rst = 1'b0;
        idle(1);
        // R10 reset state
        check("R10 expired", int'(expired), 0);
        check("R10 smi_req", int'(smi_req), 0);

        // R1 R2 R3 R9 directed: monitor 1, select 1 (16 clocks), start 3
        wr(8'h7C, 8'b00_01_00_00);
        wr(8'h7A, 8'd3);
        n = period(1, 3);
        idle(n - 1);
        check("R3 before expiry", int'(expired), 0);
        idle(1);
        check("R3 at expiry", int'(expired), 3'b010);
        check("R9 smi_req set", int'(smi_req), 1);
        // R8 sticky
        idle(40);
        check("R8 still set", int'(expired), 3'b010);
        wr(8'h7A, 8'd3);
        check("R8 cleared by start write", int'(expired), 0);
        check("R9 smi_req low", int'(smi_req), 0);

        // R4 R5: monitor 0, mask bit 5 only, select 0 (4 clocks), start 4
        clear_all();
        set_mask(0, 32'h0000_0020);
        wr(8'h7C, 8'b00_00_00_00);
        wr(8'h79, 8'd4);
        n = period(0, 4);
        idle(2);
        pulse(32'hFFFF_FFDF);              // R5: every bit except the enabled one
        idle(n - 1 - 3);
        check("R5 ignored event before", int'(expired[0]), 0);
        idle(1);
        check("R5 ignored event at expiry", int'(expired[0]), 1);
        // R8 cleared by an enabled event, then R4 shifted period
        pulse(32'h0000_0020);
        check("R8 cleared by event", int'(expired[0]), 0);
        idle(3);
        pulse(32'h0000_0020);
        idle(n - 1);
        check("R4 reload shifts expiry before", int'(expired[0]), 0);
        idle(1);
        check("R4 reload shifts expiry at", int'(expired[0]), 1);

        // R6 event on the expiry edge
        wr(8'h79, 8'd4);
        idle(n - 1);
        pulse(32'h0000_0020);
        check("R6 event wins over expiry", int'(expired[0]), 0);
        idle(n - 1);
        check("R6 new period before", int'(expired[0]), 0);
        idle(1);
        check("R6 new period at", int'(expired[0]), 1);

        // R7 zero start disables
        wr(8'h79, 8'd0);
        pulse(32'h0000_0020);
        idle(600);
        check("R7 disabled monitor", int'(expired), 0);
        check("R7 smi_req low", int'(smi_req), 0);

        // randomized countdowns, R1 R2 R3 R4
        for (int t = 0; t < 12; t++) begin
            int m, sel, st, eb, use_evt;
            logic [31:0] mk;
            m   = int'($urandom % 3);
            sel = int'($urandom % 4);
            st  = 2 + int'($urandom % ((sel == 3) ? 6 : 18));
            eb  = int'($urandom % 32);
            use_evt = int'($urandom % 2);
            mk  = $urandom | (32'd1 << eb);
            clear_all();
            for (int k = 0; k < 3; k++) set_mask(k, '0);
            set_mask(m, mk);
            wr(8'h7C, 8'(sel << (6 - 2*m)));
            wr(8'h79 + 8'(m), 8'(st));
            n = period(sel, st);
            if (use_evt != 0) begin
                idle(2);
                pulse(32'd1 << eb);
            end
            idle(n - 1);
            check("R3 random before expiry", int'(expired), 0);
            idle(1);
            check("R2 random at expiry", int'(expired), 1 << m);
            check("R1 random smi_req", int'(smi_req), 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule